// File: doc/BRIEF.md
# Echo Canceller Pair Mode and Mute Control

This block sits beside a pair of echo canceller channels, A and B, that share one group. Once per frame it takes a snapshot of each channel's 8-bit control byte and the sample format. From that snapshot it works out the group configuration: two independent channels, a back-to-back pair serving both directions of one call, or one cascaded long-tail canceller. It then routes the PCM samples. It substitutes the format's quiet code wherever a mute is requested. It passes the send input straight through in bypass. It gates adaptation on the bypass, hold and tone-detector conditions. It also reports whether the second timeslot carries meaningful data.

The adaptive filter, the tone detector and the DC offset filter are outside this block. They appear only as sample inputs (`ec_a`, `ec_b`), flags (`tone_a`, `tone_b`) and enables (`dcf_a`, `dcf_b`, `adapt_a`, `adapt_b`). Control byte layout, for both channels: bit 0 long-tail select (channel A only; channel B must keep it 0), bit 1 pair request, bit 2 receive mute, bit 3 send mute, bit 4 bypass, bit 5 hold adaptation, bit 6 ignore tone detector, bit 7 DC filter off. Format code `fmt`: 0 = 16-bit linear, 1 = sign-magnitude, 2 = mu-law, 3 = A-law.

Top module: `ec_pair_ctrl`

## Requirements
- R1: `mode` reads 1 (back-to-back) only when bit 1 is set in both snapshotted control bytes and channel A bit 0 is clear. With bit 1 set in just one byte, `mode` stays 0 (normal).
- R2: Channel A bit 0 gives `mode` = 2 (long tail), whatever the bit-1 values are. `cfg_err` is high when channel A bit 0 and both bit-1 flags are all set, or when channel B bit 0 is set.
- R3: In modes 1 and 2, `slot_b_ok` is low, `adapt_b` is low, and `rxq_b` and `tx_b` carry the quiet code. In mode 0, `slot_b_ok` is high.
- R4: Receive mute (bit 2) replaces `rin` with the quiet code on `rxq` in modes 0 and 2. The bit has no effect in mode 1.
- R5: Send mute (bit 3) drives the quiet code on `tx`. It overrides both bypass and the canceller result.
- R6: The quiet code is 16'h0000 for fmt 0, 16'h0080 for fmt 1, 16'h00FF for fmt 2 and 16'h00D5 for fmt 3.
- R7: A high tone flag forces that channel's `adapt` low unless bit 6 is set. With no mute and no bypass, `tx` carries `ec` whatever the tone flag is.
- R8: `dcf` equals the inverse of bit 7 of that channel's snapshot.
- R9: In bypass (bit 4), `tx` equals `sin` and `adapt` is low, unless send mute is set.
- R10: Bit 5 forces `adapt` low.
- R11: Control bytes and `fmt` are snapshotted only on a clock edge with `frame_start` high, and take effect from the next cycle. From reset until the first snapshot, both channels are in bypass, `mode` is 0 and no mute is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Frame boundary strobe; snapshot enable |
| ctl_a | input | 8 | Channel A control byte |
| ctl_b | input | 8 | Channel B control byte |
| fmt | input | 2 | Sample format code |
| tone_a | input | 1 | Narrow-band tone detected, channel A |
| tone_b | input | 1 | Narrow-band tone detected, channel B |
| rin_a | input | W | Receive sample in, channel A |
| sin_a | input | W | Send sample in, channel A |
| ec_a | input | W | Echo-cancelled send sample, channel A |
| rin_b | input | W | Receive sample in, channel B |
| sin_b | input | W | Send sample in, channel B |
| ec_b | input | W | Echo-cancelled send sample, channel B |
| rxq_a | output | W | Receive sample to filter and Rout, channel A |
| tx_a | output | W | Send output sample, channel A |
| rxq_b | output | W | Receive sample to filter and Rout, channel B |
| tx_b | output | W | Send output sample, channel B |
| adapt_a | output | 1 | Adaptation enable, channel A |
| adapt_b | output | 1 | Adaptation enable, channel B |
| dcf_a | output | 1 | DC offset filter enable, channel A |
| dcf_b | output | 1 | DC offset filter enable, channel B |
| slot_b_ok | output | 1 | Second timeslot carries valid data |
| cfg_err | output | 1 | Conflicting configuration bits |
| mode | output | 2 | 0 normal, 1 back-to-back, 2 long tail |

## Verification
A control byte or format change takes effect only in the cycle after the edge that sees `frame_start` high. Sample and tone inputs reach the outputs in the same cycle, through logic alone. The bench drives inputs just after a falling edge and updates its reference snapshot at each rising edge. At the next falling edge it compares every output, so both the one-cycle and the zero-cycle paths are checked in the cycle they are due. Directed phases then hold control bytes steady without the strobe, which confirms that such changes stay invisible until the next frame.

// File: rtl/ec_pair_ctrl.sv
module ec_pair_ctrl #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_start,
  input  logic [7:0]   ctl_a,
  input  logic [7:0]   ctl_b,
  input  logic [1:0]   fmt,
  input  logic         tone_a,
  input  logic         tone_b,
  input  logic [W-1:0] rin_a,
  input  logic [W-1:0] sin_a,
  input  logic [W-1:0] ec_a,
  input  logic [W-1:0] rin_b,
  input  logic [W-1:0] sin_b,
  input  logic [W-1:0] ec_b,
  output logic [W-1:0] rxq_a,
  output logic [W-1:0] tx_a,
  output logic [W-1:0] rxq_b,
  output logic [W-1:0] tx_b,
  output logic         adapt_a,
  output logic         adapt_b,
  output logic         dcf_a,
  output logic         dcf_b,
  output logic         slot_b_ok,
  output logic         cfg_err,
  output logic [1:0]   mode
);
  localparam logic [1:0] M_NORM = 2'd0, M_PAIR = 2'd1, M_LONG = 2'd2;

  logic [7:0] ca_q, cb_q;
  logic [1:0] fmt_q;
  logic       live_q;
  logic [W-1:0] quiet;
  logic       single, byp_a, byp_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ca_q <= '0; cb_q <= '0; fmt_q <= '0; live_q <= 1'b0;
    end else if (frame_start) begin
      ca_q <= ctl_a; cb_q <= ctl_b; fmt_q <= fmt; live_q <= 1'b1;
    end

  always_comb
    case (fmt_q)
      2'd1:    quiet = W'(8'h80);
      2'd2:    quiet = W'(8'hFF);
      2'd3:    quiet = W'(8'hD5);
      default: quiet = '0;
    endcase

  assign mode    = ca_q[0] ? M_LONG : (ca_q[1] & cb_q[1]) ? M_PAIR : M_NORM;
  assign cfg_err = (ca_q[0] & ca_q[1] & cb_q[1]) | cb_q[0];
  assign single  = (mode != M_NORM);
  assign slot_b_ok = ~single;

  assign byp_a = ~live_q | ca_q[4];
  assign byp_b = ~live_q | cb_q[4];

  assign rxq_a   = (ca_q[2] && mode != M_PAIR) ? quiet : rin_a;
  assign tx_a    = ca_q[3] ? quiet : byp_a ? sin_a : ec_a;
  assign adapt_a = ~byp_a & ~ca_q[5] & ~(tone_a & ~ca_q[6]);
  assign dcf_a   = ~ca_q[7];

  assign rxq_b   = single ? quiet : cb_q[2] ? quiet : rin_b;
  assign tx_b    = (single | cb_q[3]) ? quiet : byp_b ? sin_b : ec_b;
  assign adapt_b = ~single & ~byp_b & ~cb_q[5] & ~(tone_b & ~cb_q[6]);
  assign dcf_b   = ~cb_q[7];

  p_mode_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_start) |-> $stable(mode));
  p_err_long_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !cb_q[0]) |-> (mode == M_LONG));
  p_slot_b_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_b_ok |-> (!adapt_b && tx_b == quiet && rxq_b == quiet));
  p_bypass_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ca_q[4] && !ca_q[3]) |-> (tx_a == sin_a && !adapt_a));
  p_tone_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_a && !ca_q[6]) |-> !adapt_a);
  p_smute_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ca_q[3] |-> (tx_a == quiet));
endmodule

// File: tb/ec_pair_ctrl_tb.sv
module ec_pair_ctrl_tb;
  localparam int W = 16;
  logic clk = 0, rst_n = 0, frame_start = 0;
  logic [7:0] ctl_a = 0, ctl_b = 0;
  logic [1:0] fmt = 0;
  logic tone_a = 0, tone_b = 0;
  logic [W-1:0] rin_a = 0, sin_a = 0, ec_a = 0, rin_b = 0, sin_b = 0, ec_b = 0;
  logic [W-1:0] rxq_a, tx_a, rxq_b, tx_b;
  logic adapt_a, adapt_b, dcf_a, dcf_b, slot_b_ok, cfg_err;
  logic [1:0] mode;

  always #2 clk = ~clk;

  ec_pair_ctrl #(.W(W)) u_dut (.*);

  int vectors = 0, fails = 0;
  bit done = 0;
  int m_ca = 0, m_cb = 0, m_fmt = 0;
  bit m_live = 0;

  task automatic chk(string tag, int got, int exp);
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int quiet_of(int f);
    if (f == 1) return 'h80;
    if (f == 2) return 'hFF;
    if (f == 3) return 'hD5;
    return 0;
  endfunction

  task automatic compare();
    int q, md;
    bit ext, pair, ba, bb;
    int e_rxa, e_txa, e_rxb, e_txb, e_ada, e_adb;
    q = quiet_of(m_fmt);
    ext = m_ca[0]; pair = m_ca[1] && m_cb[1];
    md = ext ? 2 : (pair ? 1 : 0);
    ba = !m_live || m_ca[4];
    bb = !m_live || m_cb[4];
    e_rxa = (m_ca[2] && md != 1) ? q : int'(rin_a);
    if (m_ca[3]) e_txa = q; else if (ba) e_txa = sin_a; else e_txa = ec_a;
    e_ada = (!ba && !m_ca[5] && !(tone_a && !m_ca[6])) ? 1 : 0;
    if (md != 0) begin
      e_rxb = q; e_txb = q; e_adb = 0;
    end else begin
      e_rxb = m_cb[2] ? q : int'(rin_b);
      if (m_cb[3]) e_txb = q; else if (bb) e_txb = sin_b; else e_txb = ec_b;
      e_adb = (!bb && !m_cb[5] && !(tone_b && !m_cb[6])) ? 1 : 0;
    end
    vectors++;
    chk("R1/R2/R11 mode", mode, md);
    chk("R2 cfg_err", cfg_err, ((ext && pair) || m_cb[0]) ? 1 : 0);
    chk("R3 slot_b_ok", slot_b_ok, md == 0 ? 1 : 0);
    chk("R4/R6 rxq_a", rxq_a, e_rxa);
    chk("R5/R6/R7/R9 tx_a", tx_a, e_txa);
    chk("R7/R9/R10 adapt_a", adapt_a, e_ada);
    chk("R3/R4 rxq_b", rxq_b, e_rxb);
    chk("R3/R5/R9 tx_b", tx_b, e_txb);
    chk("R3/R7/R10 adapt_b", adapt_b, e_adb);
    chk("R8 dcf_a", dcf_a, m_ca[7] ? 0 : 1);
    chk("R8 dcf_b", dcf_b, m_cb[7] ? 0 : 1);
  endtask

  task automatic cyc(bit fs, int a, int b, int f);
    frame_start = fs; ctl_a = 8'(a); ctl_b = 8'(b); fmt = 2'(f);
    rin_a = W'($urandom); sin_a = W'($urandom); ec_a = W'($urandom);
    rin_b = W'($urandom); sin_b = W'($urandom); ec_b = W'($urandom);
    tone_a = 1'($urandom); tone_b = 1'($urandom);
    @(posedge clk);
    if (rst_n && frame_start) begin
      m_ca = ctl_a; m_cb = ctl_b; m_fmt = fmt; m_live = 1;
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    compare();
    rst_n = 1;
    // R11: reset state is bypass in normal mode
    cyc(0, 'hFF, 'hFF, 3);
    cyc(0, 'h0F, 'h02, 1);
    // R1: one-sided pair request stays normal, both sides gives back-to-back
    cyc(1, 'h02, 'h00, 0);
    cyc(1, 'h00, 'h02, 0);
    cyc(1, 'h06, 'h06, 2);
    // R2: long tail wins over pair, and channel B bit 0 flags an error
    cyc(1, 'h03, 'h02, 3);
    cyc(1, 'h01, 'h01, 1);
    // R4/R6: receive mute in every format
    for (int f = 0; f < 4; f++) cyc(1, 'h04, 'h04, f);
    // R5/R9: send mute over bypass, bypass alone
    cyc(1, 'h18, 'h10, 2);
    // R7/R10/R8: tone ignore, hold, DC off
    for (int k = 0; k < 8; k++) cyc(1, 'h40, 'h20 | 'h80, 3);
    // R11: changes without the strobe stay invisible
    for (int k = 0; k < 6; k++) cyc(0, $urandom, $urandom, $urandom);
    for (int k = 0; k < 4000; k++)
      cyc(($urandom % 4) == 0, $urandom & 'hFE | (($urandom % 8 == 0) ? 1 : 0),
          $urandom & 'hFE | (($urandom % 16 == 0) ? 1 : 0), $urandom);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule